// File: doc/BRIEF.md
# Byte-Serial 4:2:2 Video Port Receiver

This block is the receive side of a half-duplex digital video port. A sender drives luma and chroma samples with a data-valid qualifier. Only qualified cycles carry samples, so the port clock may be a fast or a gated clock. In the narrow mode the samples arrive one byte at a time on a single 8-bit lane, in the repeating order blue-difference chroma, luma, red-difference chroma, luma. In the wide mode luma and chroma arrive side by side on two 8-bit lanes. The receiver groups every four components into one pixel pair. Each pair is tagged with a start-of-line marker and the current field identity, and the pairs are queued in a small FIFO for the downstream logic.

Line and field timing comes from one of two sources. The first is external horizontal and vertical reference inputs, each with a selectable active edge and a configurable field polarity. The second, selected by a configuration bit in the narrow mode, is timing codes embedded in the byte stream. A ready output throttles the sender before the FIFO fills up. A requested change of port direction takes effect only on an active vertical reference edge, so whole fields are never split. While the port points outward, incoming data is ignored.

Top module: `vport_rx`

## Requirements
- R1: After reset the port faces outward (`dir_in`=0), `ready` is 0 and `out_valid` is 0.
- R2: `dir_in` takes the value of `dir_req` only at an active vertical reference edge, and holds its value at every other time.
- R3: While `dir_in`=0, qualified bytes produce no output pairs and `ready` stays 0.
- R4: In the narrow mode, qualified bytes are taken in the order CB, Y0, CR, Y1. Each group is delivered as `out_pix` = {CB[31:24], Y0[23:16], CR[15:8], Y1[7:0]}. Cycles with `in_valid`=0 are skipped.
- R5: In the wide mode (`cfg_wide`=1), `in_d` carries luma and `in_c` carries chroma. The first qualified cycle of a pair supplies Y0 and CB, and the second supplies Y1 and CR.
- R6: A line start resets the component phase to CB and sets `out_sol`=1 on the next pair; later pairs carry `out_sol`=0. In reference mode a line start is an active edge of `in_href`, where `cfg_href_edge`=0 selects the rising edge and 1 the falling edge. A byte qualified in the same cycle as the edge is taken as CB.
- R7: In reference mode, each active edge of `in_vref` loads the field identity with `in_href` XOR `cfg_fid_pol`. `cfg_vref_edge`=0 selects the rising edge and 1 the falling edge. Subsequent pairs carry that value on `out_fid`.
- R8: With `cfg_codes_en`=1 in the narrow mode, a code is the bytes 0xFF, 0x00, 0x00 followed by a status byte, whose bit 6 is F, bit 5 is V and bit 4 is H. A start code (H=0) loads the field identity with F. A start code with V=0 is also a line start and opens the active line. An end code (H=1), or a start code with V=1, closes the active line. Bytes outside an active line are discarded, and the reference inputs do not affect lines or field identity.
- R9: In code mode, bytes of value 0x00 or 0xFF and status bytes never enter a pixel pair.
- R10: `ready` is 1 exactly when `dir_in`=1 and the FIFO holds fewer pairs than `afull_lvl`.
- R11: A pair completed while the FIFO holds DEPTH pairs is dropped, and the pairs already held are kept.
- R12: Pairs leave in arrival order, one for each cycle in which `out_take`=1 while `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects the two-lane 16-bit mode |
| cfg_codes_en | input | 1 | 1 takes timing from embedded codes (narrow mode only) |
| cfg_href_edge | input | 1 | Active horizontal reference edge: 0 rising, 1 falling |
| cfg_vref_edge | input | 1 | Active vertical reference edge: 0 rising, 1 falling |
| cfg_fid_pol | input | 1 | Inverts the sampled field identity |
| dir_req | input | 1 | Requested direction: 1 inward, 0 outward |
| afull_lvl | input | AW+1 | Fill level at which ready drops |
| in_valid | input | 1 | Data qualifier |
| in_d | input | 8 | Byte lane (luma in the wide mode) |
| in_c | input | 8 | Chroma lane for the wide mode |
| in_href | input | 1 | Horizontal reference |
| in_vref | input | 1 | Vertical reference |
| ready | output | 1 | Sender may send |
| dir_in | output | 1 | Current direction, 1 = inward |
| out_valid | output | 1 | A pair is available |
| out_pix | output | 32 | Pixel pair {CB, Y0, CR, Y1} |
| out_sol | output | 1 | Pair is the first of its line |
| out_fid | output | 1 | Field identity of the pair |
| out_take | input | 1 | Removes the current pair |

## Verification
The hardest state to reach from the ports is code mode right after a start code, when stray 0xFF and 0x00 bytes appear inside the active line. A lone 0xFF opens a code and the next byte has to cancel it, and neither byte may shift the component phase. The bench first sends junk before any code, then a start code. It then mixes a lone 0xFF and a 0x00 into the line data and follows with an end code, trailing bytes and a blanking start code. It checks that exactly one pair, with the right field identity, comes out. FIFO saturation is reached by holding `out_take` low while more than DEPTH pairs arrive, and then draining.

// File: rtl/vport_rx.sv
module vport_rx #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic        cfg_codes_en,
  input  logic        cfg_href_edge,
  input  logic        cfg_vref_edge,
  input  logic        cfg_fid_pol,
  input  logic        dir_req,
  input  logic [AW:0] afull_lvl,
  input  logic        in_valid,
  input  logic [7:0]  in_d,
  input  logic [7:0]  in_c,
  input  logic        in_href,
  input  logic        in_vref,
  output logic        ready,
  output logic        dir_in,
  output logic        out_valid,
  output logic [31:0] out_pix,
  output logic        out_sol,
  output logic        out_fid,
  input  logic        out_take
);
  // DEPTH must be a power of two so that the pointers wrap naturally.
  logic        dir_q, href_q, vref_q, fid_q, sol_pend, active;
  logic [1:0]  ph, pc;
  logic [7:0]  cb_q, y0_q, cr_q;
  logic [33:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;

  wire codes   = cfg_codes_en & ~cfg_wide;
  wire take    = in_valid & dir_q;
  wire hedge   = cfg_href_edge ? (href_q & ~in_href) : (~href_q & in_href);
  wire vedge   = cfg_vref_edge ? (vref_q & ~in_vref) : (~vref_q & in_vref);
  wire is_xy   = codes & take & (pc == 2'd3);
  wire is_sav  = is_xy & ~in_d[4];
  wire line_st = codes ? (is_sav & ~in_d[5]) : (dir_q & hedge);
  wire rsv     = (in_d == 8'h00) | (in_d == 8'hFF);
  wire data_ok = take & (codes ? (active & ~is_xy & ~rsv) : 1'b1);
  wire [1:0] last   = cfg_wide ? 2'd1 : 2'd3;
  wire [1:0] eff_ph = line_st ? 2'd0 : ph;
  wire push    = data_ok & (eff_ph == last);
  wire full    = (cnt == (AW+1)'(DEPTH));
  wire push_ok = push & ~full;
  wire pop     = out_take & (cnt != '0);
  wire [31:0] pair = cfg_wide ? {cb_q, y0_q, in_c, in_d} : {cb_q, y0_q, cr_q, in_d};

  assign dir_in    = dir_q;
  assign ready     = dir_q & (cnt < afull_lvl);
  assign out_valid = (cnt != '0);
  assign out_pix   = mem[rp][31:0];
  assign out_fid   = mem[rp][32];
  assign out_sol   = mem[rp][33];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 1'b0; href_q <= 1'b0; vref_q <= 1'b0;
    end else begin
      href_q <= in_href;
      vref_q <= in_vref;
      if (vedge) dir_q <= dir_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= 2'd0; active <= 1'b0; fid_q <= 1'b0;
    end else begin
      if (codes) begin
        if (take) begin
          if (is_xy) begin
            pc     <= 2'd0;
            active <= ~in_d[4] & ~in_d[5];
            if (~in_d[4]) fid_q <= in_d[6];
          end else if (in_d == 8'hFF) pc <= 2'd1;
          else if (in_d == 8'h00 && pc != 2'd0) pc <= pc + 2'd1;
          else pc <= 2'd0;
        end
      end else if (vedge) begin
        fid_q <= in_href ^ cfg_fid_pol;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 2'd0; sol_pend <= 1'b0;
      cb_q <= '0; y0_q <= '0; cr_q <= '0;
    end else begin
      if (data_ok) begin
        ph <= (eff_ph == last) ? 2'd0 : eff_ph + 2'd1;
        if (cfg_wide) begin
          if (eff_ph == 2'd0) begin cb_q <= in_c; y0_q <= in_d; end
        end else begin
          case (eff_ph)
            2'd0: cb_q <= in_d;
            2'd1: y0_q <= in_d;
            2'd2: cr_q <= in_d;
            default: ;
          endcase
        end
      end else if (line_st) begin
        ph <= 2'd0;
      end
      if (line_st) sol_pend <= 1'b1;
      else if (push) sol_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= {sol_pend, fid_q, pair};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  p_full_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vedge |=> dir_q == $past(dir_q));
  p_out_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q |-> !ready);
  p_phase_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_st && !data_ok) |=> (ph == 2'd0 && sol_pend));
  p_reserved_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (codes && take && !is_xy && rsv) |=> $stable(ph));
endmodule

// File: tb/sim_vport_rx.sv
module sim_vport_rx;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  logic clk = 0, rst_n = 0;
  logic cfg_wide = 0, cfg_codes_en = 0, cfg_href_edge = 0, cfg_vref_edge = 0, cfg_fid_pol = 0;
  logic dir_req = 0;
  logic [AW:0] afull_lvl = (AW+1)'(DEPTH);
  logic in_valid = 0, in_href = 0, in_vref = 0, out_take = 0;
  logic [7:0] in_d = 0, in_c = 0;
  logic ready, dir_in, out_valid, out_sol, out_fid;
  logic [31:0] out_pix;

  vport_rx #(.DEPTH(DEPTH)) u0 (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit drain = 1, done = 0;
  logic [33:0] expq[$];
  bit exp_sol = 0, exp_fid = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(negedge clk) begin
    if (rst_n && drain && out_valid) begin
      if (expq.size() == 0) chk(0, "R12 unexpected pair", {out_sol, out_fid, out_pix}, 0);
      else begin
        logic [33:0] e;
        e = expq.pop_front();
        chk({out_sol, out_fid, out_pix} == e, "R12/R4 pair content and order", {out_sol, out_fid, out_pix}, e);
      end
      out_take = 1;
    end else out_take = 0;
  end

  task automatic put(input logic [7:0] b);
    in_valid = 1; in_d = b; @(negedge clk);
    in_valid = 0; @(negedge clk);
  endtask

  task automatic expect_pair(input logic [31:0] p);
    expq.push_back({exp_sol, exp_fid, p});
    exp_sol = 0;
  endtask

  task automatic pair8(input logic [7:0] cb, y0, cr, y1, input bit keep);
    if (keep) expect_pair({cb, y0, cr, y1}); else exp_sol = 0;
    put(cb); put(y0); put(cr); put(y1);
  endtask

  task automatic wide(input logic [7:0] y, c);
    in_valid = 1; in_d = y; in_c = c; @(negedge clk);
    in_valid = 0; @(negedge clk);
  endtask

  task automatic set_href(input logic v);
    in_href = v; @(negedge clk);
  endtask

  task automatic vpulse;
    in_vref = 1; @(negedge clk);
    in_vref = 0; @(negedge clk);
  endtask

  task automatic settle;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk(dir_in == 0, "R1 dir_in after reset", dir_in, 0);
    chk(ready == 0, "R1 ready after reset", ready, 0);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);

    dir_req = 1;
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    settle;
    chk(out_valid == 0 && expq.size() == 0, "R3 outward bytes ignored", out_valid, 0);
    chk(ready == 0, "R3 ready low outward", ready, 0);
    chk(dir_in == 0, "R2 no switch without vref edge", dir_in, 0);

    vpulse; exp_fid = 0;
    chk(dir_in == 1, "R2 switch at vref edge", dir_in, 1);
    chk(ready == 1, "R10 ready when empty", ready, 1);

    set_href(1); exp_sol = 1;
    pair8(8'h81, 8'h12, 8'h83, 8'h14, 1);
    pair8(8'h91, 8'h22, 8'h93, 8'h24, 1);
    settle;

    put(8'hAA); put(8'hBB);
    set_href(0); set_href(1); exp_sol = 1;
    pair8(8'hA1, 8'h32, 8'hA3, 8'h34, 1);
    settle;

    cfg_href_edge = 1; @(negedge clk);
    set_href(0); exp_sol = 1;
    pair8(8'hB1, 8'h42, 8'hB3, 8'h44, 1);
    settle;

    cfg_fid_pol = 1; vpulse; exp_fid = 1;
    pair8(8'hC1, 8'h52, 8'hC3, 8'h54, 1);
    settle;
    chk(expq.size() == 0, "R7 rising vref fid", expq.size(), 0);

    cfg_vref_edge = 1; set_href(1);
    vpulse; exp_fid = 0;
    pair8(8'hD1, 8'h62, 8'hD3, 8'h64, 1);
    settle;
    chk(expq.size() == 0 && dir_in == 1, "R7 falling vref fid, R2 dir held", dir_in, 1);

    cfg_wide = 1; @(negedge clk);
    set_href(0); exp_sol = 1;
    expect_pair({8'hE1, 8'h72, 8'hE3, 8'h74});
    wide(8'h72, 8'hE1); wide(8'h74, 8'hE3);
    expect_pair({8'hF1, 8'h82, 8'hF3, 8'h84});
    wide(8'h82, 8'hF1); wide(8'h84, 8'hF3);
    settle;
    chk(expq.size() == 0, "R5 wide lanes", expq.size(), 0);

    cfg_wide = 0; cfg_codes_en = 1; @(negedge clk);
    put(8'h10); put(8'h20); put(8'h30); put(8'h40);
    set_href(1); set_href(0);
    settle;
    chk(out_valid == 0, "R8 no data before start code", out_valid, 0);
    put(8'hFF); put(8'h00); put(8'h00); put(8'hC0);
    exp_sol = 1; exp_fid = 1;
    expect_pair({8'h20, 8'h30, 8'h40, 8'h50});
    put(8'h20); put(8'h00); put(8'h30); put(8'hFF); put(8'h40); put(8'h50);
    put(8'hFF); put(8'h00); put(8'h00); put(8'hD0);
    put(8'h61); put(8'h62); put(8'h63); put(8'h64);
    put(8'hFF); put(8'h00); put(8'h00); put(8'hE0);
    put(8'h71); put(8'h72); put(8'h73); put(8'h74);
    settle;
    chk(expq.size() == 0 && out_valid == 0, "R8/R9 code mode filtering", expq.size(), 0);

    cfg_codes_en = 0; drain = 0; afull_lvl = 3; @(negedge clk);
    pair8(8'h01, 8'h02, 8'h03, 8'h04, 1);
    pair8(8'h05, 8'h06, 8'h07, 8'h08, 1);
    chk(ready == 1, "R10 ready below level", ready, 1);
    pair8(8'h09, 8'h0A, 8'h0B, 8'h0C, 1);
    chk(ready == 0, "R10 ready drops at level", ready, 0);
    for (int i = 0; i < 5; i++) pair8(8'h40 + 8'(i), 8'h50, 8'h60, 8'h70, 1);
    pair8(8'hEE, 8'hEE, 8'hEE, 8'hEE, 0);
    pair8(8'hDD, 8'hDD, 8'hDD, 8'hDD, 0);
    chk(out_valid == 1 && ready == 0, "R11 full hold", out_valid, 1);
    drain = 1;
    repeat (30) @(negedge clk);
    chk(expq.size() == 0 && out_valid == 0, "R11/R12 drain after overflow", expq.size(), 0);
    chk(ready == 1, "R10 ready returns", ready, 1);

    dir_req = 0; vpulse;
    chk(dir_in == 0 && ready == 0, "R2/R3 switch outward", dir_in, 0);
    pair8(8'h31, 8'h32, 8'h33, 8'h34, 0);
    settle;
    chk(out_valid == 0, "R3 no pair outward", out_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule